// File: doc/BRIEF.md
# Windowed Command and Status Port

This block is the host-side control front end of a network controller. The host writes 16-bit command words to a single command port. It reads back a 16-bit status word that reports three things: the currently selected register window, a command-busy flag and eight interrupt status bits. A separate read-only output carries the window number, so that address decoding elsewhere in the chip can steer accesses to the right register bank.

Each command word holds a 5-bit opcode and an 11-bit argument. The commands do the following:

- select one of eight windows;
- switch the receiver and the transmitter on or off;
- request, acknowledge and mask interrupts;
- load a mask that hides status bits on read;
- load a 4-bit receive filter;
- reset the receive side, the transmit side or the whole block.

Hardware event pulses from the data path set the latched status bits. A single interrupt line is raised while any latched bit is also enabled in the interrupt mask.

The three reset commands keep the busy flag high for a parameterised number of cycles. The host polls the busy flag before it issues the next command, and any write that arrives while the flag is high is dropped.

Top module: `cmd_status_port`

## Requirements
- R1: A command word carries its opcode in bits 15:11 and its argument in bits 10:0. Argument bits that a command does not use have no effect. Opcodes 2, 6, 7, 8 and 17 to 31 change no state.
- R2: Opcode 1 loads the window number from argument bits 2:0. Status bits 15:13 and `window_o` both show the current window. After reset the window is 0.
- R3: Status bits 7:0 have these meanings: 0 interrupt latch, 1 adapter failure, 2 transmit complete, 3 transmit available, 4 receive complete, 5 receive early, 6 interrupt requested, 7 update statistics. A high `evt_i[k]` for k in 1..7 sets latched bit k at the next clock edge. `evt_i[0]` is ignored. Status bits 11:8 always read 0.
- R4: Opcode 13 clears every latched bit k for which argument bit k (k in 0..7) is 1. If a set and an acknowledge reach the same bit in the same cycle, the set wins.
- R5: Opcode 12 sets latched bit 6.
- R6: Opcode 14 loads the interrupt-enable mask from argument bits 7:0. `irq_o` is 1 exactly when the AND of the latched bits and the mask is nonzero. Latched bit 0 sets in any cycle in which some bit among 1..7 is being set while the mask in force in that cycle enables it.
- R7: Opcode 15 loads a read-zero mask from argument bits 7:0. Status bit k reads 0 whenever read-zero mask bit k is 1. The latched bits and `irq_o` are unaffected by this mask.
- R8: Opcode 16 loads `rx_filt_o` from argument bits 3:0, with bit 0 for individual, bit 1 for multicast, bit 2 for broadcast and bit 3 for promiscuous.
- R9: Opcode 4 enables receive and opcode 3 disables it. Opcode 9 enables transmit and opcode 10 disables it. Both come up disabled after reset.
- R10: Opcodes 0, 5 and 11 raise `busy_o` and status bit 12 for exactly RST_CYCLES cycles, starting in the cycle after the write. A write issued while busy is high is dropped.
- R11: Opcode 0 returns the window, both masks, the filter, both enables and all latched bits to 0, and discards any event arriving in the same cycle. Opcode 5 disables receive and clears latched bits 4 and 5. Opcode 11 disables transmit and clears latched bits 2 and 3. In both cases events on the cleared bits in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 16 | Command word: opcode and argument |
| evt_i | input | 8 | Event pulses that set latched status bits 1..7 |
| status_o | output | 16 | Status word: window, busy flag, status bits |
| window_o | output | 3 | Current window number |
| irq_o | output | 1 | Interrupt request |
| busy_o | output | 1 | Command in progress |
| rx_en_o | output | 1 | Receive enable |
| tx_en_o | output | 1 | Transmit enable |
| rx_filt_o | output | 4 | Receive filter |

## Verification
Directed sequences first step through the opcodes one at a time, each followed by a check of the full output set. This separates an opcode that acts on the wrong field from one that acts on nothing. Other directed cases put an event and an acknowledge of the same bit in one cycle, hide a set bit behind the read-zero mask while the interrupt stays up, and send commands during the busy window. A long phase of random command words and random event pulses then runs against the bench's own behavioural model, compared every cycle. That phase exposes errors in priority between simultaneous sets, clears and resets that the directed cases cannot reach.

// File: rtl/cmdif_pkg.sv
package cmdif_pkg;

   localparam int OPC_W = 5;

   typedef enum logic [OPC_W-1:0] {
      OP_GRST   = 5'd0,
      OP_WIN    = 5'd1,
      OP_RXOFF  = 5'd3,
      OP_RXON   = 5'd4,
      OP_RXRST  = 5'd5,
      OP_TXON   = 5'd9,
      OP_TXOFF  = 5'd10,
      OP_TXRST  = 5'd11,
      OP_IREQ   = 5'd12,
      OP_IACK   = 5'd13,
      OP_IMASK  = 5'd14,
      OP_RZMASK = 5'd15,
      OP_FILT   = 5'd16
   } opc_e;

   // one strobe per accepted command
   typedef struct packed {
      logic grst;
      logic win;
      logic rx_off;
      logic rx_on;
      logic rx_rst;
      logic tx_on;
      logic tx_off;
      logic tx_rst;
      logic ireq;
      logic iack;
      logic imask;
      logic rzmask;
      logic filt;
   } strb_t;

   // status bit positions
   localparam int ST_LATCH = 0;
   localparam int ST_TXC   = 2;
   localparam int ST_TXA   = 3;
   localparam int ST_RXC   = 4;
   localparam int ST_RXE   = 5;
   localparam int ST_IREQ  = 6;

endpackage

// File: rtl/cmdif_decode.sv
module cmdif_decode
   import cmdif_pkg::*;
#(
   parameter int CMD_W = 16,
   localparam int ARG_W = CMD_W - OPC_W
) (
   input  logic             valid_i,
   input  logic [CMD_W-1:0] cmd_i,
   output strb_t            strb_o,
   output logic [ARG_W-1:0] arg_o
);

   logic [OPC_W-1:0] opc;

   assign opc   = cmd_i[CMD_W-1 -: OPC_W];
   assign arg_o = cmd_i[ARG_W-1:0];

   always_comb begin
      strb_o = '0;
      if (valid_i) begin
         case (opc_e'(opc))
            OP_GRST:   strb_o.grst   = 1'b1;
            OP_WIN:    strb_o.win    = 1'b1;
            OP_RXOFF:  strb_o.rx_off = 1'b1;
            OP_RXON:   strb_o.rx_on  = 1'b1;
            OP_RXRST:  strb_o.rx_rst = 1'b1;
            OP_TXON:   strb_o.tx_on  = 1'b1;
            OP_TXOFF:  strb_o.tx_off = 1'b1;
            OP_TXRST:  strb_o.tx_rst = 1'b1;
            OP_IREQ:   strb_o.ireq   = 1'b1;
            OP_IACK:   strb_o.iack   = 1'b1;
            OP_IMASK:  strb_o.imask  = 1'b1;
            OP_RZMASK: strb_o.rzmask = 1'b1;
            OP_FILT:   strb_o.filt   = 1'b1;
            default:   strb_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/cmdif_busy.sv
module cmdif_busy #(
   parameter int RST_CYCLES = 16,
   localparam int CNT_W = (RST_CYCLES > 0) ? $clog2(RST_CYCLES + 1) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);

   generate
      if (RST_CYCLES == 0) begin : g_nobusy
         assign busy_o = 1'b0;
      end else begin : g_timer
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (start_i) begin
               cnt_q <= CNT_W'(RST_CYCLES);
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         assign busy_o = (cnt_q != '0);

         // R10
         busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            start_i |=> busy_o);

         // R10
         no_restart_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            busy_o |-> !start_i);
      end
   endgenerate

endmodule

// File: rtl/cmdif_intr.sv
module cmdif_intr
   import cmdif_pkg::*;
#(
   parameter int STAT_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [STAT_BITS-1:0] evt_i,
   input  strb_t                strb_i,
   input  logic [STAT_BITS-1:0] arg_i,
   output logic [STAT_BITS-1:0] stat_o,
   output logic                 irq_o
);

   logic [STAT_BITS-1:0] lat_q, imask_q, rz_q;
   logic [STAT_BITS-1:0] src, grp_clr, fired, set_eff;

   always_comb begin
      src            = evt_i;
      src[ST_LATCH]  = 1'b0;
      src[ST_IREQ]   = evt_i[ST_IREQ] | strb_i.ireq;

      grp_clr = '0;
      if (strb_i.rx_rst) begin
         grp_clr[ST_RXC] = 1'b1;
         grp_clr[ST_RXE] = 1'b1;
      end
      if (strb_i.tx_rst) begin
         grp_clr[ST_TXC] = 1'b1;
         grp_clr[ST_TXA] = 1'b1;
      end
      if (strb_i.grst) begin
         grp_clr = '1;
      end

      fired             = src & ~grp_clr;
      set_eff           = fired;
      set_eff[ST_LATCH] = |(fired & imask_q);
   end

   generate
      for (genvar i = 0; i < STAT_BITS; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lat_q[i] <= 1'b0;
            end else begin
               lat_q[i] <= set_eff[i]
                         | (lat_q[i] & ~(strb_i.iack & arg_i[i]) & ~grp_clr[i]);
            end
         end

         // R4
         ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (strb_i.iack && arg_i[i] && !set_eff[i]) |=> !lat_q[i]);

         // R3
         set_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_eff[i] |=> lat_q[i]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imask_q <= '0;
         rz_q    <= '0;
      end else if (strb_i.grst) begin
         imask_q <= '0;
         rz_q    <= '0;
      end else begin
         if (strb_i.imask)  imask_q <= arg_i;
         if (strb_i.rzmask) rz_q    <= arg_i;
      end
   end

   assign stat_o = lat_q & ~rz_q;
   assign irq_o  = |(lat_q & imask_q);

   // R6
   imask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb_i.imask |=> (imask_q == $past(arg_i)));

   // R11
   grst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb_i.grst |=> (lat_q == '0 && imask_q == '0 && rz_q == '0));

endmodule

// File: rtl/cmd_status_port.sv
module cmd_status_port
   import cmdif_pkg::*;
#(
   parameter int CMD_W      = 16,
   parameter int WIN_W      = 3,
   parameter int STAT_BITS  = 8,
   parameter int FILT_W     = 4,
   parameter int RST_CYCLES = 16,
   localparam int ARG_W     = CMD_W - OPC_W,
   localparam int PAD_W     = CMD_W - WIN_W - 1 - STAT_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_we,
   input  logic [CMD_W-1:0]     cmd_wdata,
   input  logic [STAT_BITS-1:0] evt_i,
   output logic [CMD_W-1:0]     status_o,
   output logic [WIN_W-1:0]     window_o,
   output logic                 irq_o,
   output logic                 busy_o,
   output logic                 rx_en_o,
   output logic                 tx_en_o,
   output logic [FILT_W-1:0]    rx_filt_o
);

   generate
      if (CMD_W != 16 || WIN_W != 3 || STAT_BITS != 8) begin : g_bad_layout
         $error("cmd_status_port: status layout requires 16/3/8");
      end
      if (FILT_W > ARG_W || STAT_BITS > ARG_W) begin : g_bad_arg
         $error("cmd_status_port: argument field too narrow");
      end
      if (PAD_W < 0) begin : g_bad_pad
         $error("cmd_status_port: status word too narrow");
      end
   endgenerate

   logic             accept;
   strb_t            strb;
   logic [ARG_W-1:0] arg;
   logic [STAT_BITS-1:0] stat_bits;
   logic [WIN_W-1:0] win_q;
   logic             rx_en_q, tx_en_q;
   logic [FILT_W-1:0] filt_q;

   assign accept = cmd_we & ~busy_o;

   cmdif_decode #(.CMD_W(CMD_W)) i_decode (
      .valid_i (accept),
      .cmd_i   (cmd_wdata),
      .strb_o  (strb),
      .arg_o   (arg)
   );

   cmdif_busy #(.RST_CYCLES(RST_CYCLES)) i_busy (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (strb.grst | strb.rx_rst | strb.tx_rst),
      .busy_o  (busy_o)
   );

   cmdif_intr #(.STAT_BITS(STAT_BITS)) i_intr (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (evt_i),
      .strb_i  (strb),
      .arg_i   (arg[STAT_BITS-1:0]),
      .stat_o  (stat_bits),
      .irq_o   (irq_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q   <= '0;
         rx_en_q <= 1'b0;
         tx_en_q <= 1'b0;
         filt_q  <= '0;
      end else if (strb.grst) begin
         win_q   <= '0;
         rx_en_q <= 1'b0;
         tx_en_q <= 1'b0;
         filt_q  <= '0;
      end else begin
         if (strb.win)                 win_q   <= arg[WIN_W-1:0];
         if (strb.rx_on)               rx_en_q <= 1'b1;
         if (strb.rx_off | strb.rx_rst) rx_en_q <= 1'b0;
         if (strb.tx_on)               tx_en_q <= 1'b1;
         if (strb.tx_off | strb.tx_rst) tx_en_q <= 1'b0;
         if (strb.filt)                filt_q  <= arg[FILT_W-1:0];
      end
   end

   assign status_o  = {win_q, busy_o, {PAD_W{1'b0}}, stat_bits};
   assign window_o  = win_q;
   assign rx_en_o   = rx_en_q;
   assign tx_en_o   = tx_en_q;
   assign rx_filt_o = filt_q;

   // R2
   window_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb.win |=> (window_o == $past(cmd_wdata[WIN_W-1:0])));

   // R10
   busy_drops_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(win_q));

   // R9
   rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.rx_off || strb.rx_rst) |=> !rx_en_o);

endmodule

// File: tb/test_cmd_status_port.sv
`timescale 1ns/1ps
module test_cmd_status_port;

   localparam int TB_RST = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic [15:0] cmd_wdata = '0;
   logic [7:0]  evt_i = '0;
   logic [15:0] status_o;
   logic [2:0]  window_o;
   logic        irq_o, busy_o, rx_en_o, tx_en_o;
   logic [3:0]  rx_filt_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit started = 1'b0;

   always #2 clk = ~clk;

   cmd_status_port #(.RST_CYCLES(TB_RST)) i_cmd_status_port (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
      .evt_i(evt_i), .status_o(status_o), .window_o(window_o), .irq_o(irq_o),
      .busy_o(busy_o), .rx_en_o(rx_en_o), .tx_en_o(tx_en_o), .rx_filt_o(rx_filt_o)
   );

   // behavioural reference model
   logic [2:0] m_win;
   logic       m_rx, m_tx;
   logic [3:0] m_filt;
   logic [7:0] m_lat, m_im, m_rz;
   int         m_cnt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_win = 0; m_rx = 0; m_tx = 0; m_filt = 0;
         m_lat = 0; m_im = 0; m_rz = 0; m_cnt = 0;
      end else begin
         automatic bit       acc = cmd_we && (m_cnt == 0);
         automatic int       op  = cmd_wdata[15:11];
         automatic logic [7:0] a = cmd_wdata[7:0];
         automatic logic [7:0] src = {evt_i[7:1], 1'b0};
         automatic logic [7:0] clrm = 8'h00;
         automatic logic [7:0] nl = m_lat;
         if (!acc) op = -1;
         if (op == 12) src[6] = 1'b1;
         if (op == 5)  clrm = 8'h30;
         if (op == 11) clrm = 8'h0C;
         if (op == 13) nl = nl & ~a;
         nl  = nl & ~clrm;
         src = src & ~clrm;
         if ((src & m_im) != 0) src[0] = 1'b1;
         nl = nl | src;
         if (m_cnt > 0) m_cnt--;
         case (op)
            0: begin
               m_win = 0; m_rx = 0; m_tx = 0; m_filt = 0;
               m_im = 0; m_rz = 0; nl = 0; m_cnt = TB_RST;
            end
            1:  m_win = cmd_wdata[2:0];
            3:  m_rx = 0;
            4:  m_rx = 1;
            5:  begin m_rx = 0; m_cnt = TB_RST; end
            9:  m_tx = 1;
            10: m_tx = 0;
            11: begin m_tx = 0; m_cnt = TB_RST; end
            14: m_im = a;
            15: m_rz = a;
            16: m_filt = cmd_wdata[3:0];
            default: ;
         endcase
         m_lat = nl;
      end
   end

   task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (started) begin
         cmp("R2 window", {status_o[15:13], window_o}, {m_win, m_win});
         cmp("R10 busy", {status_o[12], busy_o}, {2{m_cnt != 0}});
         cmp("R3 reserved bits", status_o[11:8], 4'h0);
         cmp("R7 status bits", status_o[7:0], m_lat & ~m_rz);
         cmp("R6 irq", irq_o, |(m_lat & m_im));
         cmp("R9 enables", {rx_en_o, tx_en_o}, {m_rx, m_tx});
         cmp("R8 filter", rx_filt_o, m_filt);
      end
   end

   task automatic wr(int op, int arg);
      cmd_we    = 1'b1;
      cmd_wdata = {op[4:0], arg[10:0]};
      @(negedge clk);
      cmd_we    = 1'b0;
      cmd_wdata = '0;
   endtask

   task automatic pulse(logic [7:0] e);
      evt_i = e;
      @(negedge clk);
      evt_i = '0;
   endtask

   task automatic wait_idle();
      while (busy_o) @(negedge clk);
   endtask

   initial begin
      repeat (10000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] snap;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      started = 1'b1;
      @(negedge clk);
      cmp("R9 reset state", {status_o, rx_en_o, tx_en_o, irq_o, busy_o}, '0);

      wr(1, 5);
      cmp("R2 select window 5", window_o, 3'd5);
      wr(1, 11'h7FA);
      cmp("R1 high argument bits ignored", window_o, 3'd2);

      wr(14, 8'hFE);
      pulse(8'h10);
      cmp("R3 event latched with latch bit", status_o[7:0], 8'h11);
      cmp("R6 irq raised", irq_o, 1'b1);
      pulse(8'h01);
      cmp("R3 evt bit 0 ignored", status_o[7:0], 8'h11);

      wr(15, 8'h10);
      cmp("R7 read-zero hides bit", status_o[7:0], 8'h01);
      cmp("R7 irq unaffected", irq_o, 1'b1);
      wr(13, 8'h11);
      cmp("R4 ack clears", status_o[7:0], 8'h00);
      cmp("R4 irq drops", irq_o, 1'b0);
      wr(15, 0);

      wr(12, 0);
      cmp("R5 request sets bit 6", status_o[7:0], 8'h41);

      // simultaneous event and ack on bit 2
      evt_i = 8'h04;
      wr(13, 8'h04);
      evt_i = '0;
      cmp("R4 set wins over ack", status_o[2], 1'b1);
      wr(13, 8'hFF);

      wr(16, 11'h7F5);
      cmp("R8 filter load", rx_filt_o, 4'h5);

      wr(4, 0); wr(9, 0);
      cmp("R9 enables on", {rx_en_o, tx_en_o}, 2'b11);
      wr(3, 0);
      cmp("R9 rx off", {rx_en_o, tx_en_o}, 2'b01);
      wr(4, 0);

      snap = status_o;
      foreach (snap[k]) ;
      for (int i = 0; i < 32; i++) begin
         if (i inside {2, 6, 7, 8} || i >= 17) wr(i, 11'h7FF);
      end
      cmp("R1 undefined opcodes", {status_o, rx_en_o, tx_en_o, rx_filt_o},
          {snap, 1'b1, 1'b1, 4'h5});

      pulse(8'h34);
      wr(5, 0);
      cmp("R11 rx reset clears", {rx_en_o, tx_en_o, status_o[7:0] & 8'h3C},
          {1'b0, 1'b1, 8'h04});
      cmp("R10 busy after rx reset", busy_o, 1'b1);
      wr(1, 3);
      cmp("R10 write dropped while busy", window_o, 3'd2);
      n = 1;
      while (busy_o) begin n++; @(negedge clk); end
      cmp("R10 busy length", n, TB_RST);

      pulse(8'h0C);
      wr(11, 0);
      cmp("R11 tx reset clears", {tx_en_o, status_o[3:2]}, 3'b000);
      wait_idle();

      wr(14, 8'hFF); wr(15, 8'h80); wr(4, 0); wr(1, 6);
      pulse(8'hFE);
      evt_i = 8'hFE;
      wr(0, 0);
      evt_i = '0;
      cmp("R11 global reset", {status_o[15:13], status_o[11:0], rx_en_o,
          rx_filt_o, irq_o}, '0);
      wait_idle();

      for (int c = 0; c < 3000; c++) begin
         evt_i     = 8'($urandom);
         cmd_we    = ($urandom_range(0, 1) == 1);
         cmd_wdata = 16'($urandom);
         if (cmd_wdata[15:11] == 0 && $urandom_range(0, 7) != 0)
            cmd_wdata[15:11] = 5'd13;
         @(negedge clk);
      end
      cmd_we = 1'b0;
      evt_i  = '0;
      repeat (4) @(negedge clk);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule